// File: doc/BRIEF.md
# Stream Statistics Monitor (Extreme Tracker and Threshold Counter)

This block watches a 22-bit two's complement sample stream, together with the overflow flags from the adder that produces it. It never alters the stream. Each cycle it compares the sample against a stored 22-bit reference value and, depending on two mode bits, does one of four things. It can count samples above the reference, count samples below it, track a running maximum, or track a running minimum. A 22-bit event counter records how often the chosen condition fired. The counter saturates.

The stored reference also carries two sticky history bits. One records that a positive overflow has been seen and the other that a negative overflow has been seen. A host never touches the stored reference or the counter directly. Each has a host-side buffer: the host writes a buffer and pulses a copy-in strobe to move it into the live register, or pulses a copy-out strobe to take a snapshot into the buffer. The host then reads the buffer.

Top module: `statsMonitor`

## Requirements
- R1: After reset the stored reference, its two sticky bits, the event counter and both host buffers are all zero.
- R2: With modeLess=0 and modeStatic=1 (overshoot counting), a sample with no overflow flag that is signed-greater than the stored value adds one to the counter. An equal or smaller sample changes nothing, and the stored value is never loaded in this mode.
- R3: With modeLess=1 and modeStatic=1 (undershoot counting), a sample with no overflow flag that is signed-less than the stored value adds one to the counter. An equal or larger sample changes nothing.
- R4: In the counting modes an overflow flag overrides the comparison. posOvf counts as an overshoot and never as an undershoot. negOvf counts as an undershoot and never as an overshoot.
- R5: With modeStatic=0 (tracking), modeLess=0 keeps the maximum and modeLess=1 keeps the minimum. A sample that is strictly beyond the stored value under signed order is loaded into it, and the counter adds one.
- R6: In tracking modes, a sample that arrives with either overflow flag set neither loads the stored value nor counts.
- R7: The counter stops at 0x3FFFFF and never wraps to zero.
- R8: Bit 22 of the stored register is set by any posOvf and bit 23 by any negOvf, in every mode. Each bit stays set until a copy-in.
- R9: extBufWr writes the 24-bit reference buffer. extCopyIn loads buffer bits 21:0 into the stored value and clears bits 23:22. extCopyOut copies all 24 stored bits into the buffer, and takes priority over a write in the same cycle.
- R10: cntBufWr writes the counter buffer. cntCopyIn loads the counter from the buffer. cntCopyOut copies the counter into the buffer, and takes priority over a write in the same cycle.
- R11: A copy-in in the same cycle as a stream update wins for its own register. extCopyIn overrides a load and the sticky bits, but the counter still counts that event. cntCopyIn overrides an increment.
- R12: Every copy-in and copy-out, every load and every count takes effect at the first rising clock edge at which the strobe or sample is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleData | input | 22 | Two's complement stream sample |
| posOvf | input | 1 | Sample came from a positive overflow |
| negOvf | input | 1 | Sample came from a negative overflow |
| modeLess | input | 1 | 0: greater-than / max, 1: less-than / min |
| modeStatic | input | 1 | 1: static threshold counting, 0: tracking |
| extBufWr | input | 1 | Host write strobe for the reference buffer |
| extBufWrData | input | 24 | Host data for the reference buffer |
| extCopyIn | input | 1 | Move reference buffer into the stored register |
| extCopyOut | input | 1 | Snapshot stored register into the reference buffer |
| cntBufWr | input | 1 | Host write strobe for the counter buffer |
| cntBufWrData | input | 22 | Host data for the counter buffer |
| cntCopyIn | input | 1 | Move counter buffer into the counter |
| cntCopyOut | input | 1 | Snapshot counter into the counter buffer |
| extBufOut | output | 24 | Reference buffer contents |
| cntBufOut | output | 22 | Counter buffer contents |

## Verification
The bench targets samples equal to the reference, which a design using a non-strict compare would count or load. It also drives negative samples against negative references, which an unsigned comparator misorders. It applies overflow flags with sample values that would otherwise pass or fail the compare: a design that ignored the flags would count wrongly in static modes or load garbage in tracking modes. Further cases are the counter driven up to and past 0x3FFFFF, which exposes a wrapping counter, and copy-in strobes that collide with a qualifying sample, which show up a design that lets the stream update win or drops the count.

// File: rtl/statsPkg.sv
package statsPkg;
  // Per-cycle decisions handed from the control to the datapath
  typedef struct packed {
    logic loadExt;   // replace stored value with the sample
    logic incCnt;    // event occurred, bump the counter
    logic seenPos;   // positive overflow observed
    logic seenNeg;   // negative overflow observed
  } statsStrobeT;
endpackage

// File: rtl/statsCtrl.sv
module statsCtrl
  import statsPkg::*;
#(
  parameter int DATA_W = 22
) (
  input  logic [DATA_W-1:0] sampleData,
  input  logic              posOvf,
  input  logic              negOvf,
  input  logic              modeLess,
  input  logic              modeStatic,
  input  logic [DATA_W-1:0] refValue,
  output statsStrobeT       strobe
);
  logic ovfAny;
  logic aboveRef;
  logic belowRef;
  logic hit;

  assign ovfAny   = posOvf | negOvf;
  assign aboveRef = $signed(sampleData) > $signed(refValue);
  assign belowRef = $signed(sampleData) < $signed(refValue);

  always_comb begin
    if (modeStatic) begin
      // counting: overflow flag decides, otherwise compare
      if (modeLess) hit = negOvf | (~ovfAny & belowRef);
      else          hit = posOvf | (~ovfAny & aboveRef);
    end else begin
      // tracking: overflowed samples are never trusted
      if (modeLess) hit = ~ovfAny & belowRef;
      else          hit = ~ovfAny & aboveRef;
    end
  end

  always_comb begin
    strobe.loadExt = hit & ~modeStatic;
    strobe.incCnt  = hit;
    strobe.seenPos = posOvf;
    strobe.seenNeg = negOvf;
  end
endmodule

// File: rtl/statsBuffer.sv
module statsBuffer #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostWr,
  input  logic [W-1:0] hostData,
  input  logic         snapStrobe,
  input  logic [W-1:0] liveValue,
  output logic [W-1:0] bufValue
);
  always_ff @(posedge clk) begin
    if (!rstN)           bufValue <= '0;
    else if (snapStrobe) bufValue <= liveValue;
    else if (hostWr)     bufValue <= hostData;
  end
endmodule

// File: rtl/statsDatapath.sv
module statsDatapath
  import statsPkg::*;
#(
  parameter int DATA_W = 22,
  parameter int CNT_W  = 22,
  localparam int EXT_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  statsStrobeT       strobe,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              extBufWr,
  input  logic [EXT_W-1:0]  extBufWrData,
  input  logic              extCopyIn,
  input  logic              extCopyOut,
  input  logic              cntBufWr,
  input  logic [CNT_W-1:0]  cntBufWrData,
  input  logic              cntCopyIn,
  input  logic              cntCopyOut,
  output logic [EXT_W-1:0]  storedExt,
  output logic [CNT_W-1:0]  storedCnt,
  output logic [EXT_W-1:0]  extBufOut,
  output logic [CNT_W-1:0]  cntBufOut
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DATA_W-1:0] refQ;
  logic              stickyPosQ;
  logic              stickyNegQ;
  logic [CNT_W-1:0]  cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refQ       <= '0;
      stickyPosQ <= 1'b0;
      stickyNegQ <= 1'b0;
    end else if (extCopyIn) begin
      refQ       <= extBufOut[DATA_W-1:0];
      stickyPosQ <= 1'b0;
      stickyNegQ <= 1'b0;
    end else begin
      if (strobe.loadExt) refQ <= sampleData;
      stickyPosQ <= stickyPosQ | strobe.seenPos;
      stickyNegQ <= stickyNegQ | strobe.seenNeg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                               cntQ <= '0;
    else if (cntCopyIn)                      cntQ <= cntBufOut;
    else if (strobe.incCnt && cntQ != CNT_MAX) cntQ <= cntQ + 1'b1;
  end

  assign storedExt = {stickyNegQ, stickyPosQ, refQ};
  assign storedCnt = cntQ;

  statsBuffer #(.W(EXT_W)) u_extBuf (
    .clk       (clk),
    .rstN      (rstN),
    .hostWr    (extBufWr),
    .hostData  (extBufWrData),
    .snapStrobe(extCopyOut),
    .liveValue (storedExt),
    .bufValue  (extBufOut)
  );

  statsBuffer #(.W(CNT_W)) u_cntBuf (
    .clk       (clk),
    .rstN      (rstN),
    .hostWr    (cntBufWr),
    .hostData  (cntBufWrData),
    .snapStrobe(cntCopyOut),
    .liveValue (storedCnt),
    .bufValue  (cntBufOut)
  );
endmodule

// File: rtl/statsMonitor.sv
module statsMonitor
  import statsPkg::*;
#(
  parameter int DATA_W = 22,
  parameter int CNT_W  = 22,
  localparam int EXT_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              posOvf,
  input  logic              negOvf,
  input  logic              modeLess,
  input  logic              modeStatic,
  input  logic              extBufWr,
  input  logic [EXT_W-1:0]  extBufWrData,
  input  logic              extCopyIn,
  input  logic              extCopyOut,
  input  logic              cntBufWr,
  input  logic [CNT_W-1:0]  cntBufWrData,
  input  logic              cntCopyIn,
  input  logic              cntCopyOut,
  output logic [EXT_W-1:0]  extBufOut,
  output logic [CNT_W-1:0]  cntBufOut
);
  statsStrobeT       strobe;
  logic [EXT_W-1:0]  storedExt;
  logic [CNT_W-1:0]  storedCnt;

  statsCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .sampleData(sampleData),
    .posOvf    (posOvf),
    .negOvf    (negOvf),
    .modeLess  (modeLess),
    .modeStatic(modeStatic),
    .refValue  (storedExt[DATA_W-1:0]),
    .strobe    (strobe)
  );

  statsDatapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .sampleData  (sampleData),
    .extBufWr    (extBufWr),
    .extBufWrData(extBufWrData),
    .extCopyIn   (extCopyIn),
    .extCopyOut  (extCopyOut),
    .cntBufWr    (cntBufWr),
    .cntBufWrData(cntBufWrData),
    .cntCopyIn   (cntCopyIn),
    .cntCopyOut  (cntCopyOut),
    .storedExt   (storedExt),
    .storedCnt   (storedCnt),
    .extBufOut   (extBufOut),
    .cntBufOut   (cntBufOut)
  );
endmodule

// File: rtl/statsChecker.sv
module statsChecker #(
  parameter int DATA_W = 22,
  parameter int CNT_W  = 22,
  localparam int EXT_W = DATA_W + 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] sampleData,
  input logic              posOvf,
  input logic              negOvf,
  input logic              modeStatic,
  input logic              extCopyIn,
  input logic              extCopyOut,
  input logic              cntCopyIn,
  input logic              cntCopyOut,
  input logic [EXT_W-1:0]  storedExt,
  input logic [CNT_W-1:0]  storedCnt,
  input logic [EXT_W-1:0]  extBufOut,
  input logic [CNT_W-1:0]  cntBufOut
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r2_equal_no_count: assert property (@(posedge clk) disable iff (!rstN)
    (modeStatic && !posOvf && !negOvf && sampleData == storedExt[DATA_W-1:0] && !cntCopyIn)
    |=> storedCnt == $past(storedCnt));

  a_r6_ovf_no_load: assert property (@(posedge clk) disable iff (!rstN)
    (!modeStatic && (posOvf || negOvf) && !extCopyIn)
    |=> storedExt[DATA_W-1:0] == $past(storedExt[DATA_W-1:0]));

  a_r7_cnt_saturates: assert property (@(posedge clk) disable iff (!rstN)
    (storedCnt == CNT_MAX && !cntCopyIn) |=> storedCnt == CNT_MAX);

  a_r8_sticky_pos: assert property (@(posedge clk) disable iff (!rstN)
    (posOvf && !extCopyIn) |=> storedExt[DATA_W]);

  a_r8_sticky_neg: assert property (@(posedge clk) disable iff (!rstN)
    (negOvf && !extCopyIn) |=> storedExt[DATA_W+1]);

  a_r9_copy_in: assert property (@(posedge clk) disable iff (!rstN)
    extCopyIn |=> (storedExt[EXT_W-1:DATA_W] == 2'b00 &&
                   storedExt[DATA_W-1:0] == $past(extBufOut[DATA_W-1:0])));

  a_r9_copy_out: assert property (@(posedge clk) disable iff (!rstN)
    extCopyOut |=> extBufOut == $past(storedExt));

  a_r10_copy_in: assert property (@(posedge clk) disable iff (!rstN)
    cntCopyIn |=> storedCnt == $past(cntBufOut));

  a_r10_copy_out: assert property (@(posedge clk) disable iff (!rstN)
    cntCopyOut |=> cntBufOut == $past(storedCnt));
endmodule

bind statsMonitor statsChecker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_statsChecker (
  .clk       (clk),
  .rstN      (rstN),
  .sampleData(sampleData),
  .posOvf    (posOvf),
  .negOvf    (negOvf),
  .modeStatic(modeStatic),
  .extCopyIn (extCopyIn),
  .extCopyOut(extCopyOut),
  .cntCopyIn (cntCopyIn),
  .cntCopyOut(cntCopyOut),
  .storedExt (storedExt),
  .storedCnt (storedCnt),
  .extBufOut (extBufOut),
  .cntBufOut (cntBufOut)
);

// File: tb/statsMonitor_bench.sv
module statsMonitor_bench;
  localparam logic [21:0] CMAX = 22'h3FFFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [21:0] dData = '0;
  logic        dPos = 1'b0, dNeg = 1'b0;
  logic        modeLess = 1'b0, modeStatic = 1'b1;
  logic        dExtWr = 1'b0, dExtCi = 1'b0, dExtCo = 1'b0;
  logic [23:0] dExtWrData = '0;
  logic        dCntWr = 1'b0, dCntCi = 1'b0, dCntCo = 1'b0;
  logic [21:0] dCntWrData = '0;
  logic [23:0] extBufOut;
  logic [21:0] cntBufOut;

  // bench model, built from the requirements
  logic [23:0] mExt = '0, mExtBuf = '0;
  logic [21:0] mCnt = '0, mCntBuf = '0;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;

  typedef struct {
    logic [23:0] ext;
    logic [21:0] cnt;
    string       tag;
  } expT;
  expT expQ[$];
  logic pend = 1'b0;

  always #4 clk = ~clk;

  statsMonitor u_statsMonitor (
    .clk(clk), .rstN(rstN), .sampleData(dData), .posOvf(dPos), .negOvf(dNeg),
    .modeLess(modeLess), .modeStatic(modeStatic),
    .extBufWr(dExtWr), .extBufWrData(dExtWrData), .extCopyIn(dExtCi), .extCopyOut(dExtCo),
    .cntBufWr(dCntWr), .cntBufWrData(dCntWrData), .cntCopyIn(dCntCi), .cntCopyOut(dCntCo),
    .extBufOut(extBufOut), .cntBufOut(cntBufOut)
  );

  always @(posedge clk) pend <= rstN && (dExtCo || dCntCo);

  // monitor: compares buffers one cycle after a copy-out
  always @(negedge clk) begin
    if (pend && expQ.size() > 0) begin
      expT e;
      e = expQ.pop_front();
      testsRun++;
      if (extBufOut !== e.ext) begin
        testsFailed++;
        $display("FAIL %s ref buffer: got %h expected %h", e.tag, extBufOut, e.ext);
      end
      testsRun++;
      if (cntBufOut !== e.cnt) begin
        testsFailed++;
        $display("FAIL %s count buffer: got %h expected %h", e.tag, cntBufOut, e.cnt);
      end
    end
  end

  task automatic tick(input string tag);
    logic [23:0] oExt;
    logic [21:0] oCnt;
    logic ovf, hit, gt, lt;
    oExt = mExt;
    oCnt = mCnt;
    ovf = dPos | dNeg;
    gt = $signed(dData) > $signed(oExt[21:0]);
    lt = $signed(dData) < $signed(oExt[21:0]);
    if (modeStatic) hit = modeLess ? (dNeg | (!ovf & lt)) : (dPos | (!ovf & gt));
    else            hit = !ovf & (modeLess ? lt : gt);
    if (dExtCi) mExt = {2'b00, mExtBuf[21:0]};
    else mExt = {oExt[23] | dNeg, oExt[22] | dPos,
                 (hit && !modeStatic) ? dData : oExt[21:0]};
    if (dCntCi) mCnt = mCntBuf;
    else if (hit && oCnt != CMAX) mCnt = oCnt + 1'b1;
    if (dExtCo) mExtBuf = oExt; else if (dExtWr) mExtBuf = dExtWrData;
    if (dCntCo) mCntBuf = oCnt; else if (dCntWr) mCntBuf = dCntWrData;
    if (dExtCo || dCntCo) expQ.push_back('{mExtBuf, mCntBuf, tag});
    @(posedge clk);
    #1;
    dExtWr = 0; dExtCi = 0; dExtCo = 0;
    dCntWr = 0; dCntCi = 0; dCntCo = 0;
    dPos = 0; dNeg = 0;
    dData = mExt[21:0];   // idle sample equals the reference: no action
  endtask

  task automatic sample(input logic [21:0] d, input logic p, input logic n);
    dData = d; dPos = p; dNeg = n;
    tick("");
  endtask

  task automatic readBack(input string tag);
    dExtCo = 1; dCntCo = 1;
    tick(tag);
  endtask

  task automatic setRef(input logic [23:0] v);
    dExtWr = 1; dExtWrData = v; tick("");
    dExtCi = 1; tick("");
  endtask

  task automatic setCnt(input logic [21:0] v);
    dCntWr = 1; dCntWrData = v; tick("");
    dCntCi = 1; tick("");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    testsRun++;  // R1 reset state of buffers
    if (extBufOut !== 24'h0 || cntBufOut !== 22'h0) begin
      testsFailed++;
      $display("FAIL R1 reset buffers: got %h/%h expected 0/0", extBufOut, cntBufOut);
    end
    readBack("R1 reset stored state");

    // R2 overshoot counting, static reference 100
    modeLess = 0; modeStatic = 1;
    setRef(24'd100);
    sample(22'd50, 0, 0);
    sample(22'd100, 0, 0);
    sample(22'd101, 0, 0);
    sample(-22'sd5, 0, 0);
    readBack("R2 overshoot strict compare");

    // R4/R8 overflow handling in overshoot mode
    sample(22'd3, 1, 0);
    sample(22'd900, 0, 1);
    readBack("R4 R8 overshoot overflow");

    // R3/R4/R9 undershoot counting after clearing sticky
    modeLess = 1;
    setRef(24'd100);
    readBack("R9 copy-in clears sticky");
    sample(22'd99, 0, 0);
    sample(22'd100, 0, 0);
    sample(-22'sd200000, 0, 0);
    sample(-22'sd1, 1, 0);
    sample(22'd500, 0, 1);
    readBack("R3 R4 undershoot");

    // R7 saturation
    modeLess = 0;
    setCnt(22'h3FFFFE);
    sample(22'd200, 0, 0);
    sample(22'd200, 0, 0);
    sample(22'd200, 0, 0);
    readBack("R7 counter saturates");

    // R10 host write then snapshot overrides the write
    dCntWr = 1; dCntWrData = 22'h1234; dCntCo = 1; tick("R10 copy-out beats write");
    setCnt(22'd0);
    readBack("R10 counter copy-in");

    // R5/R6 max tracking with negative values
    modeStatic = 0; modeLess = 0;
    setRef(24'h3FFC18);   // -1000 in 22 bits
    sample(-22'sd2000, 0, 0);
    sample(-22'sd500, 0, 0);
    sample(-22'sd500, 0, 0);
    sample(22'd300, 0, 0);
    sample(22'd400000, 1, 0);
    readBack("R5 R6 max tracking");

    // R5/R6 min tracking
    modeLess = 1;
    sample(22'd200, 0, 0);
    sample(22'd250, 0, 0);
    sample(-22'sd100000, 0, 1);
    sample(22'h200000, 0, 0);  // most negative value
    readBack("R5 R6 R8 min tracking");

    // R11 copy-in collides with a qualifying sample
    setRef(24'd200);
    dExtWr = 1; dExtWrData = 24'd7; tick("");
    dData = 22'd50; dExtCi = 1; tick("");
    readBack("R11 ref copy-in wins, count kept");
    dCntWr = 1; dCntWrData = 22'd40; tick("");
    dData = 22'd2; dCntCi = 1; tick("");
    readBack("R11 counter copy-in wins");

    // R12 one-cycle effect: load then immediate snapshot
    modeLess = 0;
    sample(22'd9, 0, 0);
    readBack("R12 immediate snapshot");

    repeat (4) @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run hung, got %0d cycles expected completion", cyc);
    end
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule